// File: doc/BRIEF.md
# SCSI Initiator Arbitration and Selection Sequencer

This block runs the bus-acquisition part of a SCSI initiator. A host hands it a four-bit operation code plus an attention request flag. The two long-running operations are Arbitrate and Select. Arbitrate polls the bus until it is free, claims it with this device's ID bit and BSY, and asserts SEL when it wins. Select puts both the initiator and target ID bits on the data lines, raises SEL (and ATN if requested) and drops BSY. It then waits out a fixed selection window and looks for the target's BSY.

All waiting is counted by one shared down-counter. The polling interval, settle time, bus-clear time, arbitration window and selection timeout are parameters given in clock cycles. Housekeeping operations finish in the cycle they are accepted. The host sees the results as a command-done bit, an exception interrupt bit and three sticky exception flags. The bus inputs describe what other devices drive. The bus outputs describe what this controller drives.

Top module: `scsi_init_seq`

## Requirements
- R1: Operation codes on `cmd_op`: 1 Arbitrate, 2 Select, 3/4/5/7 immediate housekeeping, 6 soft reset; 0 and 8..15 are unsupported. `cmd_atn` is used only by Select, where it drives ATN; an Arbitrate never drives ATN.
- R2: An Arbitrate accepted at edge E releases BSY, SEL, ATN and all ID lines after E, and the bus-free poll is evaluated at edge E+1.
- R3: A poll that sees BSY or SEL from another device is repeated T_BUS_FREE+1 edges later. A poll that sees a quiet bus leads to the arbitration start T_BUS_FREE+T_SETTLE+1 edges later.
- R4: If the bus is busy when arbitration starts, all lines are released and a new poll follows T_BUS_CLEAR+1 edges later.
- R5: A started arbitration drives BSY and the own ID bit (bit index = `own_id`). T_ARB+1 edges later it is won if no other device drives a higher ID bit and no other device drives SEL; a win adds SEL and keeps BSY and the ID bit.
- R6: A lost arbitration releases all lines and sets exception flag bit 0 and the exception interrupt.
- R7: Select, one edge after acceptance, drives SEL, the own and target ID bits and ATN (per R1), with BSY released. T_SEL_TIMEOUT+1 edges later, if the target drives BSY, SEL and the ID bits are released while ATN stays.
- R8: If the target has not answered at the end of the selection window, all lines are released, the sequencer goes idle, and exception flag bit 1 and the exception interrupt are set.
- R9: `seq_busy` is high from acceptance until Arbitrate or Select finishes, and commands offered while busy are ignored. `cmd_done` clears on acceptance and sets when Arbitrate or Select finishes, whatever the outcome. Codes 3, 4, 5 and 7 set it at the accepting edge and leave the bus lines unchanged.
- R10: Soft reset (code 6) releases all bus lines, clears the exception flags and interrupt, and sets `cmd_done` at the accepting edge.
- R11: An unsupported code sets `cmd_done`, exception flag bit 2 and the exception interrupt, and leaves the bus lines unchanged.
- R12: Exception flags and the interrupt are sticky and are cleared by `exc_ack` (set events win over a clear in the same cycle).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command offered this cycle |
| cmd_op | input | 4 | Operation code |
| cmd_atn | input | 1 | Attention request for Select |
| own_id | input | 3 | This controller's bus ID |
| target_id | input | 3 | Target ID for Select |
| exc_ack | input | 1 | Clear exception flags and interrupt |
| bsy_in | input | 1 | BSY driven by other devices |
| sel_in | input | 1 | SEL driven by other devices |
| id_bus_in | input | 8 | Data lines driven by other devices |
| bsy_out | output | 1 | BSY driven by this controller |
| sel_out | output | 1 | SEL driven by this controller |
| atn_out | output | 1 | ATN driven by this controller |
| id_bus_out | output | 8 | Data lines driven by this controller |
| seq_busy | output | 1 | Sequencer running |
| cmd_done | output | 1 | Command-done status |
| exc_irq | output | 1 | Exception interrupt |
| exc_flags | output | 3 | Bit 0 arbitration lost, bit 1 selection timeout, bit 2 unsupported code |

## Verification
The bench builds the block with T_BUS_FREE=4, T_SETTLE=2, T_BUS_CLEAR=3, T_ARB=5 and T_SEL_TIMEOUT=20. With these values the selection timeout and the repeated polling fit into a few dozen cycles. Bus activity can be timed so that it lands exactly in the settle wait, in the arbitration window or in the selection window. A short wait also leaves room to offer a command while the sequencer is busy and show that it has no effect.

// File: rtl/scsi_seq_pkg.sv
package scsi_seq_pkg;

    localparam int ID_W  = 3;
    localparam int BUS_W = 1 << ID_W;
    localparam int EXC_W = 3;

    localparam int EXC_ARB_LOST = 0;
    localparam int EXC_SEL_TO   = 1;
    localparam int EXC_ILLEGAL  = 2;

    typedef enum logic [2:0] {
        K_ARB,
        K_SEL,
        K_IMM,
        K_RESET,
        K_ILLEGAL
    } cmd_kind_e;

    typedef struct packed {
        cmd_kind_e kind;
        logic      atn;
    } cmd_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_POLL,
        ST_WAIT,
        ST_ARB_BEGIN,
        ST_ARB_END,
        ST_SEL_BEGIN,
        ST_SEL_END
    } seq_state_e;

    typedef struct packed {
        logic             bsy;
        logic             sel;
        logic             atn;
        logic [BUS_W-1:0] ids;
    } bus_drv_t;

    typedef struct packed {
        logic accept;
        logic done;
        logic arb_lost;
        logic sel_to;
        logic illegal;
        logic soft_rst;
    } seq_ev_t;

    function automatic cmd_t decode_cmd(input logic [3:0] op, input logic atn);
        cmd_t c;
        c.atn = atn;
        case (op)
            4'd1:                      c.kind = K_ARB;
            4'd2:                      c.kind = K_SEL;
            4'd3, 4'd4, 4'd5, 4'd7:    c.kind = K_IMM;
            4'd6:                      c.kind = K_RESET;
            default:                   c.kind = K_ILLEGAL;
        endcase
        return c;
    endfunction

    function automatic logic [BUS_W-1:0] id_bit(input logic [ID_W-1:0] id);
        return BUS_W'(1) << id;
    endfunction

    // True when any data line above bit 'id' is driven.
    function automatic logic higher_id_seen(input logic [BUS_W-1:0] bus,
                                            input logic [ID_W-1:0]  id);
        logic [BUS_W-1:0] low_mask;
        low_mask = (BUS_W'(2) << id) - BUS_W'(1);
        return |(bus & ~low_mask);
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/seq_cmd_decode.sv
module seq_cmd_decode
    import scsi_seq_pkg::*;
(
    input  logic [3:0] op,
    input  logic       atn,
    output cmd_t       cmd
);
    always_comb cmd = decode_cmd(op, atn);
endmodule

// File: rtl/seq_delay_timer.sv
module seq_delay_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expire
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)               cnt <= '0;
        else if (load)         cnt <= load_val;
        else if (cnt != '0)    cnt <= cnt - CNT_W'(1);
    end

    assign expire = (cnt == CNT_W'(1));

    assert_load_nonzero_R3: assert property (@(posedge clk) disable iff (rst)
        load |-> (load_val != '0));

    assert_expire_single_R3: assert property (@(posedge clk) disable iff (rst)
        (expire && !load) |=> !expire);
endmodule

// File: rtl/seq_core.sv
module seq_core
    import scsi_seq_pkg::*;
#(
    parameter int T_BUS_FREE    = 80,
    parameter int T_SETTLE      = 40,
    parameter int T_BUS_CLEAR   = 80,
    parameter int T_ARB         = 240,
    parameter int T_SEL_TIMEOUT = 25_000_000,
    parameter int CNT_W         = 25
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  cmd_t              cmd,
    input  logic [ID_W-1:0]   own_id,
    input  logic [ID_W-1:0]   target_id,
    input  logic              bsy_in,
    input  logic              sel_in,
    input  logic [BUS_W-1:0]  id_bus_in,
    input  logic              tmr_expire,
    output logic              tmr_load,
    output logic [CNT_W-1:0]  tmr_val,
    output bus_drv_t          drv,
    output logic              busy,
    output seq_ev_t           ev
);
    localparam logic [CNT_W-1:0] D_POLL_BUSY = CNT_W'(T_BUS_FREE);
    localparam logic [CNT_W-1:0] D_POLL_FREE = CNT_W'(T_BUS_FREE + T_SETTLE);
    localparam logic [CNT_W-1:0] D_CLEAR     = CNT_W'(T_BUS_CLEAR);
    localparam logic [CNT_W-1:0] D_ARB       = CNT_W'(T_ARB);
    localparam logic [CNT_W-1:0] D_SEL       = CNT_W'(T_SEL_TIMEOUT);

    seq_state_e state, nxt;
    logic       atn_req;
    logic       quiet, win, accept;

    assign quiet  = !bsy_in && !sel_in;
    assign win    = !sel_in && !higher_id_seen(id_bus_in, own_id);
    assign accept = cmd_valid && (state == ST_IDLE);
    assign busy   = (state != ST_IDLE);

    always_comb begin
        ev        = '0;
        ev.accept = accept;
        tmr_load  = 1'b0;
        tmr_val   = '0;
        case (state)
            ST_IDLE: if (accept) begin
                case (cmd.kind)
                    K_IMM:     ev.done = 1'b1;
                    K_RESET:   begin ev.done = 1'b1; ev.soft_rst = 1'b1; end
                    K_ILLEGAL: begin ev.done = 1'b1; ev.illegal  = 1'b1; end
                    default:   ;
                endcase
            end
            ST_POLL: begin
                tmr_load = 1'b1;
                tmr_val  = quiet ? D_POLL_FREE : D_POLL_BUSY;
            end
            ST_ARB_BEGIN: begin
                tmr_load = 1'b1;
                tmr_val  = quiet ? D_ARB : D_CLEAR;
            end
            ST_ARB_END: begin
                ev.done     = 1'b1;
                ev.arb_lost = !win;
            end
            ST_SEL_BEGIN: begin
                tmr_load = 1'b1;
                tmr_val  = D_SEL;
            end
            ST_SEL_END: begin
                ev.done   = 1'b1;
                ev.sel_to = !bsy_in;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            nxt     <= ST_IDLE;
            drv     <= '0;
            atn_req <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: if (cmd_valid) begin
                    case (cmd.kind)
                        K_ARB: begin
                            drv   <= '0;
                            state <= ST_POLL;
                        end
                        K_SEL: begin
                            atn_req <= cmd.atn;
                            state   <= ST_SEL_BEGIN;
                        end
                        K_RESET: drv <= '0;
                        default: ;
                    endcase
                end
                ST_POLL: begin
                    nxt   <= quiet ? ST_ARB_BEGIN : ST_POLL;
                    state <= ST_WAIT;
                end
                ST_WAIT: if (tmr_expire) state <= nxt;
                ST_ARB_BEGIN: begin
                    if (quiet) begin
                        drv.bsy <= 1'b1;
                        drv.ids <= id_bit(own_id);
                        nxt     <= ST_ARB_END;
                    end else begin
                        drv <= '0;
                        nxt <= ST_POLL;
                    end
                    state <= ST_WAIT;
                end
                ST_ARB_END: begin
                    if (win) drv.sel <= 1'b1;
                    else     drv     <= '0;
                    state <= ST_IDLE;
                end
                ST_SEL_BEGIN: begin
                    drv.bsy <= 1'b0;
                    drv.sel <= 1'b1;
                    drv.atn <= atn_req;
                    drv.ids <= id_bit(own_id) | id_bit(target_id);
                    nxt     <= ST_SEL_END;
                    state   <= ST_WAIT;
                end
                ST_SEL_END: begin
                    if (bsy_in) begin
                        drv.sel <= 1'b0;
                        drv.ids <= '0;
                    end else begin
                        drv <= '0;
                    end
                    state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // A win keeps the claim on the bus while SEL goes up.
    assert_win_keeps_claim_R5: assert property (@(posedge clk) disable iff (rst)
        ($rose(drv.sel) && ($past(state) == ST_ARB_END)) |-> (drv.bsy && |(drv.ids & id_bit(own_id))));

    // The end of arbitration is reached only through a timed wait.
    assert_arb_end_after_wait_R5: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ARB_END) |-> ($past(state) == ST_WAIT));

    // Selection drops BSY while it drives SEL.
    assert_select_drops_bsy_R7: assert property (@(posedge clk) disable iff (rst)
        ($past(state) == ST_SEL_BEGIN) |-> (drv.sel && !drv.bsy));
endmodule

// File: rtl/seq_status.sv
module seq_status
    import scsi_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  seq_ev_t          ev,
    input  logic             exc_ack,
    output logic             done,
    output logic [EXC_W-1:0] flags,
    output logic             irq
);
    logic [EXC_W-1:0] set_bits;

    always_comb begin
        set_bits               = '0;
        set_bits[EXC_ARB_LOST] = ev.arb_lost;
        set_bits[EXC_SEL_TO]   = ev.sel_to;
        set_bits[EXC_ILLEGAL]  = ev.illegal;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            done  <= 1'b0;
            flags <= '0;
            irq   <= 1'b0;
        end else begin
            if (ev.done)        done <= 1'b1;
            else if (ev.accept) done <= 1'b0;

            if (ev.soft_rst) begin
                flags <= '0;
                irq   <= 1'b0;
            end else begin
                flags <= (exc_ack ? '0 : flags) | set_bits;
                if (|set_bits)   irq <= 1'b1;
                else if (exc_ack) irq <= 1'b0;
            end
        end
    end

    assert_flags_sticky_R12: assert property (@(posedge clk) disable iff (rst)
        ((flags != '0) && !exc_ack && !ev.soft_rst) |=> ((flags & $past(flags)) == $past(flags)));
endmodule

// File: rtl/scsi_init_seq.sv
module scsi_init_seq
    import scsi_seq_pkg::*;
#(
    parameter int T_BUS_FREE    = 80,
    parameter int T_SETTLE      = 40,
    parameter int T_BUS_CLEAR   = 80,
    parameter int T_ARB         = 240,
    parameter int T_SEL_TIMEOUT = 25_000_000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_valid,
    input  logic [3:0]       cmd_op,
    input  logic             cmd_atn,
    input  logic [ID_W-1:0]  own_id,
    input  logic [ID_W-1:0]  target_id,
    input  logic             exc_ack,
    input  logic             bsy_in,
    input  logic             sel_in,
    input  logic [BUS_W-1:0] id_bus_in,
    output logic             bsy_out,
    output logic             sel_out,
    output logic             atn_out,
    output logic [BUS_W-1:0] id_bus_out,
    output logic             seq_busy,
    output logic             cmd_done,
    output logic             exc_irq,
    output logic [EXC_W-1:0] exc_flags
);
    localparam int MAX_DLY = max2(max2(T_BUS_FREE + T_SETTLE, T_BUS_CLEAR),
                                  max2(T_ARB, T_SEL_TIMEOUT));
    localparam int CNT_W   = $clog2(MAX_DLY + 1);

    cmd_t             cmd;
    bus_drv_t         drv;
    seq_ev_t          ev;
    logic             tmr_load, tmr_expire;
    logic [CNT_W-1:0] tmr_val;

    seq_cmd_decode u_dec (
        .op  (cmd_op),
        .atn (cmd_atn),
        .cmd (cmd)
    );

    seq_delay_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expire   (tmr_expire)
    );

    seq_core #(
        .T_BUS_FREE    (T_BUS_FREE),
        .T_SETTLE      (T_SETTLE),
        .T_BUS_CLEAR   (T_BUS_CLEAR),
        .T_ARB         (T_ARB),
        .T_SEL_TIMEOUT (T_SEL_TIMEOUT),
        .CNT_W         (CNT_W)
    ) u_core (
        .clk        (clk),
        .rst        (rst),
        .cmd_valid  (cmd_valid),
        .cmd        (cmd),
        .own_id     (own_id),
        .target_id  (target_id),
        .bsy_in     (bsy_in),
        .sel_in     (sel_in),
        .id_bus_in  (id_bus_in),
        .tmr_expire (tmr_expire),
        .tmr_load   (tmr_load),
        .tmr_val    (tmr_val),
        .drv        (drv),
        .busy       (seq_busy),
        .ev         (ev)
    );

    seq_status u_stat (
        .clk     (clk),
        .rst     (rst),
        .ev      (ev),
        .exc_ack (exc_ack),
        .done    (cmd_done),
        .flags   (exc_flags),
        .irq     (exc_irq)
    );

    assign bsy_out    = drv.bsy;
    assign sel_out    = drv.sel;
    assign atn_out    = drv.atn;
    assign id_bus_out = drv.ids;

    assert_arb_releases_R2: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !seq_busy && cmd_op == 4'd1) |=>
            (!bsy_out && !sel_out && !atn_out && id_bus_out == '0 && seq_busy));

    assert_loss_releases_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(exc_flags[EXC_ARB_LOST]) |-> (!bsy_out && !sel_out && id_bus_out == '0 && exc_irq));

    assert_timeout_releases_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(exc_flags[EXC_SEL_TO]) |->
            (!seq_busy && !bsy_out && !sel_out && !atn_out && id_bus_out == '0));

    assert_done_when_idle_R9: assert property (@(posedge clk) disable iff (rst)
        cmd_done |-> !seq_busy);

    assert_illegal_untouched_R11: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !seq_busy && (cmd_op == 4'd0 || cmd_op[3])) |=>
            ($stable(bsy_out) && $stable(sel_out) && $stable(atn_out) && $stable(id_bus_out)));
endmodule

// File: tb/sim_scsi_init_seq.sv
module sim_scsi_init_seq;
    localparam int CLK_PERIOD = 10;
    localparam int TB_FREE    = 4;
    localparam int TB_SETTLE  = 2;
    localparam int TB_CLEAR   = 3;
    localparam int TB_ARB     = 5;
    localparam int TB_SELTO   = 20;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cmd_valid = 1'b0;
    logic [3:0] cmd_op = '0;
    logic       cmd_atn = 1'b0;
    logic [2:0] own_id = 3'd6;
    logic [2:0] target_id = 3'd2;
    logic       exc_ack = 1'b0;
    logic       bsy_in = 1'b0;
    logic       sel_in = 1'b0;
    logic [7:0] id_bus_in = '0;
    logic       bsy_out, sel_out, atn_out, seq_busy, cmd_done, exc_irq;
    logic [7:0] id_bus_out;
    logic [2:0] exc_flags;

    // reference expectations
    logic       e_bsy = 0, e_sel = 0, e_atn = 0, e_busy = 0, e_done = 0, e_irq = 0;
    logic [7:0] e_ids = '0;
    logic [2:0] e_flags = '0;

    int    checks = 0;
    int    errors = 0;
    bit    cmp_en = 0;
    bit    finished = 0;
    string cur_req = "R9";

    always #(CLK_PERIOD/2) clk = ~clk;

    scsi_init_seq #(
        .T_BUS_FREE(TB_FREE), .T_SETTLE(TB_SETTLE), .T_BUS_CLEAR(TB_CLEAR),
        .T_ARB(TB_ARB), .T_SEL_TIMEOUT(TB_SELTO)
    ) u0 (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_atn(cmd_atn),
        .own_id(own_id), .target_id(target_id), .exc_ack(exc_ack),
        .bsy_in(bsy_in), .sel_in(sel_in), .id_bus_in(id_bus_in),
        .bsy_out(bsy_out), .sel_out(sel_out), .atn_out(atn_out), .id_bus_out(id_bus_out),
        .seq_busy(seq_busy), .cmd_done(cmd_done), .exc_irq(exc_irq), .exc_flags(exc_flags)
    );

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: got %0h expected %0h at %0t", cur_req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (cmp_en) begin
            chk(bsy_out === e_bsy,      "bsy_out",    int'(bsy_out),    int'(e_bsy));
            chk(sel_out === e_sel,      "sel_out",    int'(sel_out),    int'(e_sel));
            chk(atn_out === e_atn,      "atn_out",    int'(atn_out),    int'(e_atn));
            chk(id_bus_out === e_ids,   "id_bus_out", int'(id_bus_out), int'(e_ids));
            chk(seq_busy === e_busy,    "seq_busy",   int'(seq_busy),   int'(e_busy));
            chk(cmd_done === e_done,    "cmd_done",   int'(cmd_done),   int'(e_done));
            chk(exc_irq === e_irq,      "exc_irq",    int'(exc_irq),    int'(e_irq));
            chk(exc_flags === e_flags,  "exc_flags",  int'(exc_flags),  int'(e_flags));
        end
    end

    function automatic logic [7:0] onehot(input logic [2:0] id);
        return 8'd1 << id;
    endfunction

    // Offer a command in idle and apply its acceptance-edge effects to the model.
    task automatic issue(input logic [3:0] op, input logic atn);
        @(negedge clk);
        cmd_op = op; cmd_atn = atn; cmd_valid = 1'b1;
        @(posedge clk);
        case (op)
            4'd1: begin e_bsy = 0; e_sel = 0; e_atn = 0; e_ids = '0; e_busy = 1; e_done = 0; end
            4'd2: begin e_busy = 1; e_done = 0; end
            4'd3, 4'd4, 4'd5, 4'd7: e_done = 1;
            4'd6: begin e_bsy = 0; e_sel = 0; e_atn = 0; e_ids = '0;
                        e_flags = '0; e_irq = 0; e_done = 1; end
            default: begin e_done = 1; e_flags[2] = 1'b1; e_irq = 1; end
        endcase
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    // Behavioural model of an arbitration after acceptance (R3, R4, R5, R6).
    task automatic model_arb();
        bit started = 0;
        while (!started) begin
            @(posedge clk);
            if (bsy_in || sel_in) begin
                repeat (TB_FREE) @(posedge clk);
            end else begin
                repeat (TB_FREE + TB_SETTLE) @(posedge clk);
                @(posedge clk);
                if (bsy_in || sel_in) begin
                    e_bsy = 0; e_sel = 0; e_atn = 0; e_ids = '0;
                    repeat (TB_CLEAR) @(posedge clk);
                end else begin
                    e_bsy = 1; e_ids = onehot(own_id);
                    started = 1;
                end
            end
        end
        repeat (TB_ARB) @(posedge clk);
        @(posedge clk);
        if (!sel_in && ((id_bus_in >> (int'(own_id) + 1)) == 8'd0)) begin
            e_sel = 1;
        end else begin
            e_bsy = 0; e_sel = 0; e_atn = 0; e_ids = '0;
            e_flags[0] = 1'b1; e_irq = 1;
        end
        e_done = 1; e_busy = 0;
    endtask

    // Behavioural model of a selection after acceptance (R7, R8).
    task automatic model_sel(input logic atn);
        @(posedge clk);
        e_sel = 1; e_bsy = 0; e_atn = atn; e_ids = onehot(own_id) | onehot(target_id);
        repeat (TB_SELTO) @(posedge clk);
        @(posedge clk);
        if (bsy_in) begin
            e_sel = 0; e_ids = '0;
        end else begin
            e_bsy = 0; e_sel = 0; e_atn = 0; e_ids = '0;
            e_flags[1] = 1'b1; e_irq = 1;
        end
        e_done = 1; e_busy = 0;
    endtask

    task automatic ack_exc();
        @(negedge clk);
        exc_ack = 1'b1;
        @(posedge clk);
        e_flags = '0; e_irq = 0;
        @(negedge clk);
        exc_ack = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        cmp_en = 1;
        cur_req = "R9 reset state";
        idle(2);

        // R2 R5 R1: arbitrate on a quiet bus, a lower ID present, ATN request ignored
        cur_req = "R5";
        own_id = 3'd6; id_bus_in = 8'h10;
        issue(4'd1, 1'b1);
        model_arb();
        idle(2);

        // R9: housekeeping codes finish at once and leave the claimed bus alone
        cur_req = "R9";
        issue(4'd3, 1'b0); idle(1);
        issue(4'd4, 1'b0); idle(1);
        issue(4'd5, 1'b0); idle(1);
        issue(4'd7, 1'b0); idle(1);

        // R11: unsupported codes
        cur_req = "R11";
        issue(4'd0, 1'b0); idle(1);
        issue(4'd12, 1'b0); idle(1);

        // R12: acknowledge clears flags and interrupt
        cur_req = "R12";
        ack_exc(); idle(1);

        // R10: soft reset releases the bus
        cur_req = "R10";
        issue(4'd11, 1'b0); idle(1);
        issue(4'd6, 1'b0); idle(2);

        // R3: bus busy at first, repeated polling
        cur_req = "R3";
        id_bus_in = '0; bsy_in = 1'b1;
        issue(4'd1, 1'b0);
        fork
            model_arb();
            begin repeat (13) @(negedge clk); bsy_in = 1'b0; end
        join
        idle(2);

        // R4: bus turns busy during the settle wait
        cur_req = "R4";
        issue(4'd6, 1'b0);
        issue(4'd1, 1'b0);
        fork
            model_arb();
            begin
                repeat (3) @(negedge clk); bsy_in = 1'b1;
                repeat (10) @(negedge clk); bsy_in = 1'b0;
            end
        join
        idle(2);

        // R6: loss to a higher ID
        cur_req = "R6";
        issue(4'd6, 1'b0);
        own_id = 3'd3; id_bus_in = 8'h20;
        issue(4'd1, 1'b0);
        model_arb();
        idle(2);

        cur_req = "R12";
        ack_exc(); idle(1);

        // R6: loss because another device drives SEL in the window
        cur_req = "R6";
        own_id = 3'd5; id_bus_in = '0;
        issue(4'd1, 1'b0);
        fork
            model_arb();
            begin
                repeat (10) @(negedge clk); sel_in = 1'b1;
                repeat (8) @(negedge clk); sel_in = 1'b0;
            end
        join
        idle(2);

        // R9: command offered while busy is ignored; highest ID wins over all lower ones
        cur_req = "R9";
        issue(4'd6, 1'b0);
        own_id = 3'd7; id_bus_in = 8'h7F;
        issue(4'd1, 1'b0);
        fork
            model_arb();
            begin
                repeat (4) @(negedge clk);
                cmd_op = 4'd6; cmd_valid = 1'b1;
                @(negedge clk);
                cmd_valid = 1'b0;
            end
        join
        idle(2);

        // R7 R1: select with attention, target answers
        cur_req = "R7";
        issue(4'd6, 1'b0);
        own_id = 3'd6; target_id = 3'd2; id_bus_in = '0;
        issue(4'd2, 1'b1);
        fork
            model_sel(1'b1);
            begin
                repeat (10) @(negedge clk); bsy_in = 1'b1;
                repeat (14) @(negedge clk); bsy_in = 1'b0;
            end
        join
        idle(2);

        // R8: select without attention, no answer
        cur_req = "R8";
        issue(4'd6, 1'b0);
        target_id = 3'd0;
        issue(4'd2, 1'b0);
        model_sel(1'b0);
        idle(2);

        cur_req = "R12";
        ack_exc(); idle(2);

        cmp_en = 0;
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            cmp_en = 0;
            errors++;
            $display("FAIL watchdog: run did not complete, got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule